// File: doc/BRIEF.md
# Dual-Bank Matrix Product Sequencer

This block steers the data flow of a square matrix product C = A x B built from small unsigned elements. The rows of A and the columns of B are each held as one wide word, spread over two memory banks by index parity. Each bank feeds its own first-word-fall-through input queue. Rows and columns with odd 1-based index (0-based index even) sit in queue 1, and those with even 1-based index sit in queue 2. The sequencer decides, cycle by cycle, which queue to pop. It captures a pair of A rows into two row registers and streams every B column past them. Two external dot-product pipelines, one per row register, take the column word together with their row. When a pass ends, the sequencer moves on by two rows.

The two pipeline results of one column come back together. They are zero-padded to 32 bits each and written as one 64-bit word to a result queue. The result for the lower row goes in the low half. The result queue signals through an almost-full flag that it cannot take another column's worth of in-flight results, and the sequencer holds off column issue while that flag is set. A start pulse, taken only while idle, begins a product. A one-cycle done pulse closes it once the last result word has been written.

Top module: `mmseq_top`

## Requirements
- R1: After reset, busy, done, col_valid, rf_wr, q1_pop and q2_pop are all low until a start pulse is accepted.
- R2: After an accepted start, each pass first pops queue 1 and captures that word in row_a (row i, 0-based even), then pops queue 2 and captures that word in row_b (row i+1). The first pass uses rows 0 and 1.
- R3: In a pass, the N columns are issued in index order. Column j (0-based) is popped from queue 1 when j is even and from queue 2 when j is odd, so the last column comes from queue 2. The popped word is presented on col_word, with col_valid high, in the same cycle.
- R4: After column N-1 of a pass, the row index advances by 2 and a new row pair is loaded. After the pass over rows N-2 and N-1, no further queue is popped.
- R5: A queue is never popped in a cycle in which its empty flag is high. The sequence waits in place until data is there.
- R6: No column is issued (col_valid, and the column pop) in a cycle in which rf_afull is high.
- R7: One cycle after res_valid, rf_wr is high with rf_data = {pad, res_b, pad, res_a}. res_a occupies bits [RES_W-1:0], res_b occupies bits [32+RES_W-1:32], and every other bit is zero.
- R8: done is high for exactly one cycle, in the cycle after the (N*N/2)-th result write of the product. busy falls in the cycle after done.
- R9: A start pulse while busy is high is ignored: the queue pop order and result count of the running product are unchanged.
- R10: At most one of q1_pop and q2_pop is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a product (accepted only when idle) |
| q1_empty | input | 1 | Queue 1 (odd-index bank) empty |
| q1_data | input | N*ELEM_W | Queue 1 head word |
| q1_pop | output | 1 | Pop queue 1 |
| q2_empty | input | 1 | Queue 2 (even-index bank) empty |
| q2_data | input | N*ELEM_W | Queue 2 head word |
| q2_pop | output | 1 | Pop queue 2 |
| row_a | output | N*ELEM_W | Row register for pipeline 1 (row i) |
| row_b | output | N*ELEM_W | Row register for pipeline 2 (row i+1) |
| col_word | output | N*ELEM_W | Column word for both pipelines |
| col_valid | output | 1 | Column word valid this cycle |
| res_valid | input | 1 | Both pipeline results valid |
| res_a | input | 2*ELEM_W+clog2(N) | Result for row i |
| res_b | input | 2*ELEM_W+clog2(N) | Result for row i+1 |
| rf_afull | input | 1 | Result queue cannot take more in-flight results |
| rf_wr | output | 1 | Result queue write |
| rf_data | output | 64 | Packed result pair |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase or wrong column parity inside the sequencer shows in the same cycle as a pop on the wrong queue, or as a column word that differs from the queue head. A bad row-register capture or a wrong packing order shows as a wrong result word one pipeline latency plus one cycle later. A wrong row-index step or a wrong pass count shows only at the end of the product: the queues drain unevenly, the number of result words is off, or done arrives early or late. The bench compares pops, column words, row registers, busy, done and write timing against a behavioural model on every clock. It also checks the data of every result word against a software matrix product, under queue gaps, back-pressure and a start pulse sent while busy.

// File: rtl/mmseq_pkg.sv
package mmseq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ROW_A = 3'd1,
      PH_ROW_B = 3'd2,
      PH_COLS  = 3'd3,
      PH_DRAIN = 3'd4
   } phase_t;
endpackage

// File: rtl/mmseq_ctrl.sv
module mmseq_ctrl
   import mmseq_pkg::*;
#(
   parameter int N = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic q1_empty,
   input  logic q2_empty,
   input  logic rf_afull,
   input  logic done,
   output logic q1_pop,
   output logic q2_pop,
   output logic load_a,
   output logic load_b,
   output logic issue,
   output logic sel_b,
   output logic go,
   output logic busy
);
   localparam int IW = $clog2(N);
   localparam logic [IW-1:0] LAST_COL = IW'(N - 1);
   localparam logic [IW-1:0] LAST_ROW = IW'(N - 2);

   phase_t ph;
   logic [IW-1:0] row;
   logic [IW-1:0] col;
   logic src_empty;

   always_comb begin
      go        = start && (ph == PH_IDLE);
      load_a    = (ph == PH_ROW_A) && !q1_empty;
      load_b    = (ph == PH_ROW_B) && !q2_empty;
      sel_b     = col[0];
      src_empty = sel_b ? q2_empty : q1_empty;
      issue     = (ph == PH_COLS) && !src_empty && !rf_afull;
      q1_pop    = load_a || (issue && !sel_b);
      q2_pop    = load_b || (issue && sel_b);
      busy      = (ph != PH_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         row <= '0;
         col <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: if (go) begin
               ph  <= PH_ROW_A;
               row <= '0;
               col <= '0;
            end
            PH_ROW_A: if (load_a) ph <= PH_ROW_B;
            PH_ROW_B: if (load_b) begin
               ph  <= PH_COLS;
               col <= '0;
            end
            PH_COLS: if (issue) begin
               if (col == LAST_COL) begin
                  col <= '0;
                  if (row == LAST_ROW) ph <= PH_DRAIN;
                  else begin
                     row <= row + IW'(2);
                     ph  <= PH_ROW_A;
                  end
               end else begin
                  col <= col + IW'(1);
               end
            end
            PH_DRAIN: if (done) ph <= PH_IDLE;
            default:  ph <= PH_IDLE;
         endcase
      end
   end

   // R5: never pop an empty queue
   assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (q1_pop |-> !q1_empty) and (q2_pop |-> !q2_empty));
   // R10: one queue per cycle
   assert_one_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({q1_pop, q2_pop}));
   // R6: back-pressure blocks column issue
   assert_no_issue_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_afull |-> !issue);
   // R9: start while running keeps the product running
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> busy);
endmodule

// File: rtl/mmseq_rowregs.sv
module mmseq_rowregs #(
   parameter int W       = 1024,
   parameter bit REG_COL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_a,
   input  logic         load_b,
   input  logic         issue,
   input  logic         sel_b,
   input  logic [W-1:0] q1_data,
   input  logic [W-1:0] q2_data,
   output logic [W-1:0] row_a,
   output logic [W-1:0] row_b,
   output logic [W-1:0] col_word,
   output logic         col_valid
);
   logic [W-1:0] col_src;

   assign col_src = sel_b ? q2_data : q1_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_a <= '0;
         row_b <= '0;
      end else begin
         if (load_a) row_a <= q1_data;
         if (load_b) row_b <= q2_data;
      end
   end

   generate
      if (REG_COL) begin : g_reg_col
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               col_valid <= 1'b0;
               col_word  <= '0;
            end else begin
               col_valid <= issue;
               if (issue) col_word <= col_src;
            end
         end
      end else begin : g_comb_col
         assign col_valid = issue;
         assign col_word  = col_src;
      end
   endgenerate

   // R2: a row register changes only when it is loaded
   assert_row_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load_a |=> $stable(row_a));
endmodule

// File: rtl/mmseq_pack.sv
module mmseq_pack #(
   parameter int RES_W = 23,
   parameter int TOTAL = 8192
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             res_valid,
   input  logic [RES_W-1:0] res_a,
   input  logic [RES_W-1:0] res_b,
   output logic             rf_wr,
   output logic [63:0]      rf_data,
   output logic             done
);
   localparam int PAD = 32 - RES_W;
   localparam int CW  = $clog2(TOTAL + 1);
   localparam logic [CW-1:0] LAST_WR = CW'(TOTAL - 1);

   logic [CW-1:0] wr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rf_wr   <= 1'b0;
         rf_data <= '0;
         wr_cnt  <= '0;
         done    <= 1'b0;
      end else begin
         rf_wr <= res_valid;
         if (res_valid) rf_data <= {{PAD{1'b0}}, res_b, {PAD{1'b0}}, res_a};
         if (go) wr_cnt <= '0;
         else if (rf_wr) wr_cnt <= wr_cnt + CW'(1);
         done <= rf_wr && (wr_cnt == LAST_WR) && !go;
      end
   end

   // R7: every write follows a result one cycle earlier
   assert_wr_follows_res_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |-> $past(res_valid));
   // R8: done is a single pulse right after a write
   assert_done_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rf_wr));
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/mmseq_top.sv
module mmseq_top #(
   parameter int N       = 128,
   parameter int ELEM_W  = 8,
   parameter bit REG_COL = 1'b0,
   localparam int W      = N * ELEM_W,
   localparam int RES_W  = 2 * ELEM_W + $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             q1_empty,
   input  logic [W-1:0]     q1_data,
   output logic             q1_pop,
   input  logic             q2_empty,
   input  logic [W-1:0]     q2_data,
   output logic             q2_pop,
   output logic [W-1:0]     row_a,
   output logic [W-1:0]     row_b,
   output logic [W-1:0]     col_word,
   output logic             col_valid,
   input  logic             res_valid,
   input  logic [RES_W-1:0] res_a,
   input  logic [RES_W-1:0] res_b,
   input  logic             rf_afull,
   output logic             rf_wr,
   output logic [63:0]      rf_data,
   output logic             busy,
   output logic             done
);
   localparam int TOTAL = N * N / 2;

   generate
      if (N < 2 || (N % 2) != 0) begin : g_bad_n
         $error("mmseq_top: N must be even and at least 2");
      end
      if (RES_W > 31) begin : g_bad_res
         $error("mmseq_top: result width must leave padding in 32 bits");
      end
   endgenerate

   logic load_a, load_b, issue, sel_b, go;

   mmseq_ctrl #(.N(N)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .q1_empty(q1_empty), .q2_empty(q2_empty), .rf_afull(rf_afull), .done(done),
      .q1_pop(q1_pop), .q2_pop(q2_pop), .load_a(load_a), .load_b(load_b),
      .issue(issue), .sel_b(sel_b), .go(go), .busy(busy)
   );

   mmseq_rowregs #(.W(W), .REG_COL(REG_COL)) u_rows (
      .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
      .issue(issue), .sel_b(sel_b), .q1_data(q1_data), .q2_data(q2_data),
      .row_a(row_a), .row_b(row_b), .col_word(col_word), .col_valid(col_valid)
   );

   mmseq_pack #(.RES_W(RES_W), .TOTAL(TOTAL)) u_pack (
      .clk(clk), .rst_n(rst_n), .go(go), .res_valid(res_valid),
      .res_a(res_a), .res_b(res_b), .rf_wr(rf_wr), .rf_data(rf_data), .done(done)
   );
endmodule

// File: tb/sim_mmseq_top.sv
`timescale 1ns/1ps
module sim_mmseq_top;
   localparam int N     = 4;
   localparam int EW    = 8;
   localparam int LAT   = 3;
   localparam int W     = N * EW;
   localparam int RW    = 2 * EW + $clog2(N);
   localparam int TOTAL = N * N / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic q1_empty = 1'b1, q2_empty = 1'b1;
   logic [W-1:0] q1_data = '0, q2_data = '0;
   logic q1_pop, q2_pop, col_valid, rf_wr, busy, done;
   logic [W-1:0] row_a, row_b, col_word;
   logic res_valid;
   logic [RW-1:0] res_a, res_b;
   logic rf_afull = 1'b0;
   logic [63:0] rf_data;

   always #2 clk = ~clk;

   mmseq_top #(.N(N), .ELEM_W(EW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .q1_empty(q1_empty), .q1_data(q1_data), .q1_pop(q1_pop),
      .q2_empty(q2_empty), .q2_data(q2_data), .q2_pop(q2_pop),
      .row_a(row_a), .row_b(row_b), .col_word(col_word), .col_valid(col_valid),
      .res_valid(res_valid), .res_a(res_a), .res_b(res_b), .rf_afull(rf_afull),
      .rf_wr(rf_wr), .rf_data(rf_data), .busy(busy), .done(done)
   );

   // ---------------- environment: queues and pipelines ----------------
   logic [W-1:0] q1[$];
   logic [W-1:0] q2[$];
   logic [63:0]  expq[$];
   int A[N][N];
   int B[N][N];

   function automatic logic [RW-1:0] dotw(logic [W-1:0] r, logic [W-1:0] c);
      int s = 0;
      for (int k = 0; k < N; k++) s += int'(r[k*EW +: EW]) * int'(c[k*EW +: EW]);
      return RW'(s);
   endfunction

   logic          pv [LAT];
   logic [RW-1:0] pa [LAT];
   logic [RW-1:0] pb [LAT];
   assign res_valid = pv[LAT-1];
   assign res_a     = pa[LAT-1];
   assign res_b     = pb[LAT-1];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < LAT; s++) begin pv[s] <= 1'b0; pa[s] <= '0; pb[s] <= '0; end
      end else begin
         for (int s = LAT - 1; s > 0; s--) begin
            pv[s] <= pv[s-1]; pa[s] <= pa[s-1]; pb[s] <= pb[s-1];
         end
         pv[0] <= col_valid;
         pa[0] <= dotw(row_a, col_word);
         pb[0] <= dotw(row_b, col_word);
      end
   end

   always @(posedge clk) begin
      if (q1_pop && q1.size() > 0) void'(q1.pop_front());
      if (q2_pop && q2.size() > 0) void'(q2.pop_front());
   end

   // ---------------- checking ----------------
   int nchk = 0, nfail = 0;
   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural model state
   int mph = 0, mrow = 0, mcol = 0, mwr = 0;
   logic [W-1:0] m_ra = '0, m_rb = '0;
   bit wr_due = 0, done_due = 0, start_next = 0;
   int gap_pct = 0, af_pct = 0;
   int done_cnt = 0, word_cnt = 0;

   task automatic step();
      bit e1, e2, af, x1, x2, xcv;
      @(negedge clk);
      start = start_next; start_next = 0;
      e1 = (q1.size() == 0) || (($urandom % 100) < gap_pct);
      e2 = (q2.size() == 0) || (($urandom % 100) < gap_pct);
      af = (($urandom % 100) < af_pct);
      q1_empty = e1; q2_empty = e2; rf_afull = af;
      q1_data = (q1.size() > 0) ? q1[0] : '0;
      q2_data = (q2.size() > 0) ? q2[0] : '0;
      #1;
      xcv = (mph == 3) && (((mcol % 2) == 0) ? !e1 : !e2) && !af;
      x1  = (mph == 1 && !e1) || (xcv && (mcol % 2) == 0);
      x2  = (mph == 2 && !e2) || (xcv && (mcol % 2) == 1);
      chk(q1_pop == x1, "R3/R5/R6 q1_pop", 64'(q1_pop), 64'(x1));
      chk(q2_pop == x2, "R3/R5/R6 q2_pop", 64'(q2_pop), 64'(x2));
      chk(!(q1_pop && q2_pop), "R10 single pop", {q1_pop, q2_pop}, 64'd0);
      chk(col_valid == xcv, "R6 col_valid", 64'(col_valid), 64'(xcv));
      if (xcv) chk(col_word == (((mcol % 2) == 0) ? q1_data : q2_data), "R3 col_word",
                   64'(col_word), 64'(((mcol % 2) == 0) ? q1_data : q2_data));
      chk(row_a == m_ra && row_b == m_rb, "R2 row registers", {row_a, row_b}, {m_ra, m_rb});
      chk(busy == (mph != 0), "R8/R9 busy", 64'(busy), 64'(mph != 0));
      chk(done == done_due, "R8 done", 64'(done), 64'(done_due));
      chk(rf_wr == wr_due, "R7 rf_wr timing", 64'(rf_wr), 64'(wr_due));
      if (rf_wr) begin
         word_cnt++;
         if (expq.size() == 0) chk(0, "R7 extra word", rf_data, 64'd0);
         else begin
            logic [63:0] ew;
            ew = expq.pop_front();
            chk(rf_data == ew, "R7 rf_data", rf_data, ew);
         end
      end
      if (done) done_cnt++;
      // advance the model across the coming edge
      done_due = 0;
      if (wr_due) begin mwr++; if (mwr == TOTAL) done_due = 1; end
      wr_due = res_valid;
      case (mph)
         0: if (start) begin mph = 1; mrow = 0; mcol = 0; mwr = 0; end
         1: if (!e1) begin m_ra = q1_data; mph = 2; end
         2: if (!e2) begin m_rb = q2_data; mph = 3; mcol = 0; end
         3: if (xcv) begin
            if (mcol == N - 1) begin
               mcol = 0;
               if (mrow == N - 2) mph = 4; else begin mrow += 2; mph = 1; end
            end else mcol++;
         end
         4: if (done) mph = 0;
         default: mph = 0;
      endcase
   endtask

   function automatic logic [W-1:0] rowword(int i);
      logic [W-1:0] w;
      for (int k = 0; k < N; k++) w[k*EW +: EW] = EW'(A[i][k]);
      return w;
   endfunction
   function automatic logic [W-1:0] colword(int j);
      logic [W-1:0] w;
      for (int k = 0; k < N; k++) w[k*EW +: EW] = EW'(B[k][j]);
      return w;
   endfunction

   task automatic load(int mode);
      q1.delete(); q2.delete(); expq.delete();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            A[i][j] = (mode == 0) ? 255 : int'($urandom % 256);
            B[i][j] = (mode == 0) ? 255 : int'($urandom % 256);
         end
      for (int p = 0; p < N / 2; p++) begin
         q1.push_back(rowword(2 * p));
         q2.push_back(rowword(2 * p + 1));
         for (int j = 0; j < N; j++) begin
            int c0, c1;
            logic [63:0] w;
            if (j % 2 == 0) q1.push_back(colword(j)); else q2.push_back(colword(j));
            c0 = 0; c1 = 0;
            for (int k = 0; k < N; k++) begin
               c0 += A[2*p][k] * B[k][j];
               c1 += A[2*p+1][k] * B[k][j];
            end
            w = '0;
            w[RW-1:0]    = RW'(c0);
            w[32 +: RW]  = RW'(c1);
            expq.push_back(w);
         end
      end
   endtask

   task automatic run(int mode, int gp, int ap, bit late_start, string name);
      int n;
      bit seen;
      load(mode);
      gap_pct = gp; af_pct = ap;
      done_cnt = 0; word_cnt = 0;
      start_next = 1;
      n = 0; seen = 0;
      while (!seen && n < 5000) begin
         if (late_start && n == 12) start_next = 1;   // R9: start while busy
         step();
         if (done) seen = 1;
         n++;
      end
      if (!seen) chk(0, {"R8 watchdog ", name}, 64'(n), 64'd0);
      for (int k = 0; k < 4; k++) step();
      chk(word_cnt == TOTAL, {"R4/R8 word count ", name}, 64'(word_cnt), 64'(TOTAL));
      chk(done_cnt == 1, {"R8 done count ", name}, 64'(done_cnt), 64'd1);
      chk(q1.size() == 0 && q2.size() == 0, {"R4/R9 queues drained ", name},
          64'(q1.size() + q2.size()), 64'd0);
      chk(busy == 1'b0, {"R8 idle after done ", name}, 64'(busy), 64'd0);
   endtask

   initial begin
      for (int k = 0; k < 3; k++) step();
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) step();
      // R1: reset state
      chk(!busy && !done && !col_valid && !rf_wr && !q1_pop && !q2_pop, "R1 reset state",
          {busy, done, col_valid, rf_wr, q1_pop, q2_pop}, 64'd0);
      run(0, 0, 0, 0, "max elements");
      run(1, 30, 0, 0, "queue gaps");
      run(1, 0, 40, 0, "back-pressure");
      run(1, 25, 25, 1, "start while busy");
      $display("  %0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule